// File: doc/BRIEF.md
# DMA Channel Abort Sequencer

This block takes abort events for the manager thread and for a set of channel threads of a DMA engine and runs an ordered shutdown for each aborted channel. Causes come from the bus response logic (an error response on a data load or a data store), from the FIFO checker (a load that would not fit, or a store that finds too little data for its bus transfer) and from the lock-up watchdog. The bus master, the instruction cache and the instruction queues lie outside the block. The block reaches them through simple request/acknowledge handshakes and per-channel in-flight flags.

An aborted channel is halted at once. A single sequencer then takes one channel at a time through five steps. It first invalidates the channel's cache lines. It then purges the channel's queued, unissued read and write entries. Next it waits until the channel's active bus transfers have drained. It then writes the faulting instruction address into the channel program counter, but only when the abort is precise. Last, it records the fault. A fault stays until software issues a kill for that thread. Manager aborts need no sequence and are recorded one edge after they arrive. Any recorded fault drives the shared abort interrupt and its sideband copy.

Sequencer states and transitions: IDLE goes to HALT when any channel is pending, taking the lowest-numbered one. HALT goes to INVAL after one cycle. INVAL goes to PURGE on the cache acknowledge. PURGE goes to DRAIN on the purge acknowledge. DRAIN goes to DONE once the channel has no transfer in flight. DONE goes back to IDLE after one cycle, and the fault is recorded on that edge.

Top module: `dma_abort_seq`

## Requirements
- R1: A `ch_abort_req[i]` pulse on a channel that is neither pending nor faulting sets `ch_halt[i]` at the next clock edge. The flag stays high until a kill clears that channel's fault.
- R2: For the channel being processed, `cache_inv_req` is raised with `cache_inv_ch` equal to that channel. Both are held steady until `cache_inv_ack`.
- R3: `queue_purge_req` with `queue_purge_ch` equal to the channel rises only after the invalidate handshake has completed. It never overlaps `cache_inv_req`.
- R4: A channel's fault bit is not set while its `ch_inflight` bit is high. It is set once the bit has been low and the sequence has finished.
- R5: A precise abort produces exactly one `pc_wr_en` pulse with `pc_wr_ch` equal to the channel and `pc_wr_data` equal to the captured abort address. An imprecise abort produces no pulse.
- R6: The captured cause appears in `ch_cause[2i+1:2i]` (channel i) or `mgr_cause`, coded 0 load error, 1 store error, 2 FIFO error, 3 watchdog.
- R7: `abort_irq` and `abort_irq_sb` are both high exactly while any channel fault bit or `mgr_fault` is set.
- R8: When several channels abort in the same cycle, all are halted, the lowest-numbered is sequenced first, and the others wait as pending.
- R9: An abort for a channel that is already pending, in sequence or faulting is ignored: no new sequence starts and the first cause is kept.
- R10: A kill (`kill_valid`, `kill_mgr`=0, `kill_ch`=i) clears the fault bit and the halt of a faulting channel at the next edge. A kill for a channel that is not faulting has no effect.
- R11: `mgr_abort_req` sets `mgr_fault` and `mgr_cause` at the next edge without starting a channel sequence. A kill with `kill_mgr`=1 clears it.
- R12: After reset all halt, fault, cause, request, write and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_abort_req | input | NUM_CH | Per-channel abort pulse |
| ch_abort_cause | input | 2*NUM_CH | Per-channel cause code, 2 bits each |
| ch_abort_precise | input | NUM_CH | Abort is precise |
| ch_abort_pc | input | NUM_CH*PC_W | Address of the aborting instruction, per channel |
| mgr_abort_req | input | 1 | Manager abort pulse |
| mgr_abort_cause | input | 2 | Manager cause code |
| kill_valid | input | 1 | Software kill command |
| kill_mgr | input | 1 | Kill targets the manager |
| kill_ch | input | CH_IDX_W | Channel targeted by the kill |
| ch_inflight | input | NUM_CH | Channel has bus transfers in flight |
| cache_inv_ack | input | 1 | Cache invalidate done |
| queue_purge_ack | input | 1 | Queue purge done |
| ch_halt | output | NUM_CH | Stop instruction execution for the channel |
| ch_fault | output | NUM_CH | Channel fault status |
| ch_cause | output | 2*NUM_CH | Channel fault cause |
| mgr_fault | output | 1 | Manager fault status |
| mgr_cause | output | 2 | Manager fault cause |
| cache_inv_req | output | 1 | Invalidate a channel's cache lines |
| cache_inv_ch | output | CH_IDX_W | Channel to invalidate |
| queue_purge_req | output | 1 | Drop a channel's unissued queue entries |
| queue_purge_ch | output | CH_IDX_W | Channel to purge |
| pc_wr_en | output | 1 | Program counter write strobe |
| pc_wr_ch | output | CH_IDX_W | Channel whose program counter is written |
| pc_wr_data | output | PC_W | Address written |
| abort_irq | output | 1 | Shared abort interrupt |
| abort_irq_sb | output | 1 | Sideband copy of the interrupt |

## Verification
A sequencer stuck in one state shows up at the ports within a handful of cycles. Either a handshake request stays up without moving on, or the fault bit never rises, and the bench catches that by bounding every wait. A wrong channel index or a broken priority pick shows up on the first invalidate after a multi-channel abort, as a wrong `cache_inv_ch`. A lost pending slot shows up as a channel that stays halted and never faults. A drain check that ignores the in-flight flags shows up as a fault bit set while the bench still holds `ch_inflight` high.

// File: rtl/abt_pkg.sv
package abt_pkg;
    typedef enum logic [1:0] {
        CAUSE_LOAD  = 2'd0,
        CAUSE_STORE = 2'd1,
        CAUSE_FIFO  = 2'd2,
        CAUSE_WDOG  = 2'd3
    } abt_cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HALT,
        S_INVAL,
        S_PURGE,
        S_DRAIN,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/abt_pend_slot.sv
module abt_pend_slot #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [1:0]      cause_in,
    input  logic            precise_in,
    input  logic [PC_W-1:0] pc_in,
    input  logic            done,
    input  logic            kill,
    output logic            pend,
    output logic            fault,
    output logic [1:0]      cause_q,
    output logic            precise_q,
    output logic [PC_W-1:0] pc_q
);
    // A slot accepts a new abort only when idle; it moves pending -> fault on done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            fault     <= 1'b0;
            cause_q   <= '0;
            precise_q <= 1'b0;
            pc_q      <= '0;
        end else if (!pend && !fault && req) begin
            pend      <= 1'b1;
            cause_q   <= cause_in;
            precise_q <= precise_in;
            pc_q      <= pc_in;
        end else if (pend && done) begin
            pend  <= 1'b0;
            fault <= 1'b1;
        end else if (fault && kill) begin
            fault <= 1'b0;
        end
    end

    // R9: a busy slot keeps its first cause
    assert_keep_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend || fault) |=> $stable(cause_q));
endmodule

// File: rtl/abt_pick.sv
module abt_pick #(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]   req,
    output logic                found,
    output logic [CH_IDX_W-1:0] idx
);
    // Lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = CH_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/abt_seq_fsm.sv
module abt_seq_fsm
    import abt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   pend_vec,
    input  logic [NUM_CH-1:0]   inflight,
    input  logic                inv_ack,
    input  logic                purge_ack,
    output logic [CH_IDX_W-1:0] cur_ch,
    output logic                inv_req,
    output logic                purge_req,
    output logic                done
);
    seq_state_e                state, state_nx;
    logic                      found;
    logic [CH_IDX_W-1:0]       pick_idx;

    abt_pick #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_pick (
        .req   (pend_vec),
        .found (found),
        .idx   (pick_idx)
    );

    // State register and current channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur_ch <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && found) cur_ch <= pick_idx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (found) state_nx = S_HALT;
            S_HALT:  state_nx = S_INVAL;
            S_INVAL: if (inv_ack) state_nx = S_PURGE;
            S_PURGE: if (purge_ack) state_nx = S_DRAIN;
            S_DRAIN: if (!inflight[cur_ch]) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        inv_req   = 1'b0;
        purge_req = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_INVAL: inv_req   = 1'b1;
            S_PURGE: purge_req = 1'b1;
            S_DONE:  done      = 1'b1;
            default: ;
        endcase
    end

    // R2: the invalidate request holds with a stable channel until acknowledged
    assert_inv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_ack) |=> (inv_req && $stable(cur_ch)));
    // R3: purge starts only after a completed invalidate handshake
    assert_purge_after_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(purge_req) |-> $past(inv_req && inv_ack));
endmodule

// File: rtl/dma_abort_seq.sv
module dma_abort_seq
    import abt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int PC_W     = 32,
    parameter int CH_IDX_W = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH-1:0]      ch_abort_req,
    input  logic [2*NUM_CH-1:0]    ch_abort_cause,
    input  logic [NUM_CH-1:0]      ch_abort_precise,
    input  logic [NUM_CH*PC_W-1:0] ch_abort_pc,
    input  logic                   mgr_abort_req,
    input  logic [1:0]             mgr_abort_cause,
    input  logic                   kill_valid,
    input  logic                   kill_mgr,
    input  logic [CH_IDX_W-1:0]    kill_ch,
    input  logic [NUM_CH-1:0]      ch_inflight,
    input  logic                   cache_inv_ack,
    input  logic                   queue_purge_ack,
    output logic [NUM_CH-1:0]      ch_halt,
    output logic [NUM_CH-1:0]      ch_fault,
    output logic [2*NUM_CH-1:0]    ch_cause,
    output logic                   mgr_fault,
    output logic [1:0]             mgr_cause,
    output logic                   cache_inv_req,
    output logic [CH_IDX_W-1:0]    cache_inv_ch,
    output logic                   queue_purge_req,
    output logic [CH_IDX_W-1:0]    queue_purge_ch,
    output logic                   pc_wr_en,
    output logic [CH_IDX_W-1:0]    pc_wr_ch,
    output logic [PC_W-1:0]        pc_wr_data,
    output logic                   abort_irq,
    output logic                   abort_irq_sb
);
    logic [NUM_CH-1:0]   pend_vec;
    logic [NUM_CH-1:0]   prec_vec;
    logic [PC_W-1:0]     pc_arr [NUM_CH];
    logic [CH_IDX_W-1:0] cur_ch;
    logic                seq_done;
    abt_cause_e          mgr_cause_q;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            abt_pend_slot #(.PC_W(PC_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .req        (ch_abort_req[i]),
                .cause_in   (ch_abort_cause[2*i +: 2]),
                .precise_in (ch_abort_precise[i]),
                .pc_in      (ch_abort_pc[PC_W*i +: PC_W]),
                .done       (seq_done && (cur_ch == CH_IDX_W'(i))),
                .kill       (kill_valid && !kill_mgr && (kill_ch == CH_IDX_W'(i))),
                .pend       (pend_vec[i]),
                .fault      (ch_fault[i]),
                .cause_q    (ch_cause[2*i +: 2]),
                .precise_q  (prec_vec[i]),
                .pc_q       (pc_arr[i])
            );
            assign ch_halt[i] = pend_vec[i] | ch_fault[i];

            // R1: a fresh abort halts the channel at the next edge
            assert_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_abort_req[i] && !ch_fault[i]) |=> ch_halt[i]);
            // R4: no fault is recorded while transfers were still in flight
            assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_fault[i]) |-> !$past(ch_inflight[i]));
        end
    endgenerate

    abt_seq_fsm #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_vec  (pend_vec),
        .inflight  (ch_inflight),
        .inv_ack   (cache_inv_ack),
        .purge_ack (queue_purge_ack),
        .cur_ch    (cur_ch),
        .inv_req   (cache_inv_req),
        .purge_req (queue_purge_req),
        .done      (seq_done)
    );

    assign cache_inv_ch   = cur_ch;
    assign queue_purge_ch = cur_ch;
    assign pc_wr_en       = seq_done && prec_vec[cur_ch];
    assign pc_wr_ch       = cur_ch;
    assign pc_wr_data     = pc_arr[cur_ch];

    // Manager fault record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mgr_fault   <= 1'b0;
            mgr_cause_q <= CAUSE_LOAD;
        end else if (!mgr_fault && mgr_abort_req) begin
            mgr_fault   <= 1'b1;
            mgr_cause_q <= abt_cause_e'(mgr_abort_cause);
        end else if (mgr_fault && kill_valid && kill_mgr) begin
            mgr_fault <= 1'b0;
        end
    end
    assign mgr_cause = mgr_cause_q;

    assign abort_irq    = (|ch_fault) | mgr_fault;
    assign abort_irq_sb = (|ch_fault) | mgr_fault;

    // R5: a program counter write targets a halted, still pending channel
    assert_pcwr_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |-> (ch_halt[pc_wr_ch] && !ch_fault[pc_wr_ch]));
    // R11: a manager abort is recorded at the next edge
    assert_mgr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_abort_req && !mgr_fault) |=> mgr_fault);
    // R7: both interrupt lines follow the recorded faults
    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_fault) || mgr_fault) |-> (abort_irq && abort_irq_sb));
endmodule

// File: tb/tb_dma_abort_seq.sv
module tb_dma_abort_seq;
    localparam int NUM_CH = 4;
    localparam int PC_W   = 32;
    localparam int IW     = 2;

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  cause;
        logic        precise;
        logic [31:0] pc;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{ch: 2'd2, cause: 2'd1, precise: 1'b1, pc: 32'h0000_0100},
        '{ch: 2'd0, cause: 2'd0, precise: 1'b1, pc: 32'h0000_2A40},
        '{ch: 2'd3, cause: 2'd2, precise: 1'b0, pc: 32'hDEAD_0004},
        '{ch: 2'd1, cause: 2'd3, precise: 1'b0, pc: 32'h0000_0010},
        '{ch: 2'd3, cause: 2'd0, precise: 1'b1, pc: 32'hFFFF_FFFC},
        '{ch: 2'd0, cause: 2'd2, precise: 1'b1, pc: 32'h1234_5678}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NUM_CH-1:0]      ch_abort_req = '0;
    logic [2*NUM_CH-1:0]    ch_abort_cause = '0;
    logic [NUM_CH-1:0]      ch_abort_precise = '0;
    logic [NUM_CH*PC_W-1:0] ch_abort_pc = '0;
    logic                   mgr_abort_req = 1'b0;
    logic [1:0]             mgr_abort_cause = '0;
    logic                   kill_valid = 1'b0;
    logic                   kill_mgr = 1'b0;
    logic [IW-1:0]          kill_ch = '0;
    logic [NUM_CH-1:0]      ch_inflight = '0;
    logic                   cache_inv_ack = 1'b0;
    logic                   queue_purge_ack = 1'b0;
    logic [NUM_CH-1:0]      ch_halt, ch_fault;
    logic [2*NUM_CH-1:0]    ch_cause;
    logic                   mgr_fault;
    logic [1:0]             mgr_cause;
    logic                   cache_inv_req, queue_purge_req, pc_wr_en;
    logic [IW-1:0]          cache_inv_ch, queue_purge_ch, pc_wr_ch;
    logic [PC_W-1:0]        pc_wr_data;
    logic                   abort_irq, abort_irq_sb;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    dma_abort_seq #(.NUM_CH(NUM_CH), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ch_abort_req(ch_abort_req), .ch_abort_cause(ch_abort_cause),
        .ch_abort_precise(ch_abort_precise), .ch_abort_pc(ch_abort_pc),
        .mgr_abort_req(mgr_abort_req), .mgr_abort_cause(mgr_abort_cause),
        .kill_valid(kill_valid), .kill_mgr(kill_mgr), .kill_ch(kill_ch),
        .ch_inflight(ch_inflight), .cache_inv_ack(cache_inv_ack),
        .queue_purge_ack(queue_purge_ack),
        .ch_halt(ch_halt), .ch_fault(ch_fault), .ch_cause(ch_cause),
        .mgr_fault(mgr_fault), .mgr_cause(mgr_cause),
        .cache_inv_req(cache_inv_req), .cache_inv_ch(cache_inv_ch),
        .queue_purge_req(queue_purge_req), .queue_purge_ch(queue_purge_ch),
        .pc_wr_en(pc_wr_en), .pc_wr_ch(pc_wr_ch), .pc_wr_data(pc_wr_data),
        .abort_irq(abort_irq), .abort_irq_sb(abort_irq_sb)
    );

    // Handshake responders for the cache and queue models
    always @(negedge clk) begin
        cache_inv_ack   <= cache_inv_req & ~cache_inv_ack;
        queue_purge_ack <= queue_purge_req & ~queue_purge_ack;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] ch, input logic [1:0] cause,
                         input logic prec, input logic [31:0] pc);
        ch_abort_req[ch]           = 1'b1;
        ch_abort_cause[2*ch +: 2]  = cause;
        ch_abort_precise[ch]       = prec;
        ch_abort_pc[PC_W*ch +: PC_W] = pc;
    endtask

    task automatic kill_one(input logic [1:0] ch, input logic mgr);
        @(negedge clk);
        kill_valid = 1'b1; kill_mgr = mgr; kill_ch = ch;
        @(negedge clk);
        kill_valid = 1'b0; kill_mgr = 1'b0;
    endtask

    task automatic run_abort(input vec_t v, input bit do_kill);
        int inv_n = 0; int pur_n = 0; int pcw_n = 0;
        logic [31:0] pcd = '0; logic [1:0] pch = '0;
        bit order_ok = 1'b1;
        @(negedge clk);
        issue(v.ch, v.cause, v.precise, v.pc);
        @(negedge clk);
        ch_abort_req = '0;
        chk(ch_halt[v.ch] == 1'b1, "R1 halt after abort", 64'(ch_halt), 64'(1 << v.ch));
        for (int k = 0; k < 40 && !ch_fault[v.ch]; k++) begin
            if (cache_inv_req) begin
                inv_n++;
                if (cache_inv_ch != v.ch || pur_n != 0) order_ok = 1'b0;
            end
            if (queue_purge_req) begin
                pur_n++;
                if (queue_purge_ch != v.ch || inv_n == 0 || cache_inv_req) order_ok = 1'b0;
            end
            if (pc_wr_en) begin pcw_n++; pcd = pc_wr_data; pch = pc_wr_ch; end
            @(negedge clk);
        end
        chk(inv_n > 0 && order_ok, "R2 invalidate for channel", 64'(inv_n), 64'(1));
        chk(pur_n > 0 && order_ok, "R3 purge after invalidate", 64'(pur_n), 64'(1));
        chk(ch_fault[v.ch] == 1'b1, "R4 fault after drain", 64'(ch_fault), 64'(1 << v.ch));
        chk(ch_cause[2*v.ch +: 2] == v.cause, "R6 cause code",
            64'(ch_cause[2*v.ch +: 2]), 64'(v.cause));
        if (v.precise)
            chk(pcw_n == 1 && pcd == v.pc && pch == v.ch, "R5 precise pc write",
                64'(pcd), 64'(v.pc));
        else
            chk(pcw_n == 0, "R5 no pc write when imprecise", 64'(pcw_n), 64'(0));
        chk(abort_irq && abort_irq_sb, "R7 irq with fault",
            64'({abort_irq, abort_irq_sb}), 64'(3));
        if (do_kill) begin
            kill_one(v.ch, 1'b0);
            chk(!ch_fault[v.ch] && !ch_halt[v.ch], "R10 kill clears",
                64'({ch_fault, ch_halt}), 64'(0));
            chk(!abort_irq && !abort_irq_sb, "R7 irq drops",
                64'({abort_irq, abort_irq_sb}), 64'(0));
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(ch_halt == 0 && ch_fault == 0 && ch_cause == 0 && !mgr_fault && mgr_cause == 0,
            "R12 reset status", 64'({ch_halt, ch_fault, ch_cause}), 64'(0));
        chk(!cache_inv_req && !queue_purge_req && !pc_wr_en && !abort_irq && !abort_irq_sb,
            "R12 reset outputs", 64'({cache_inv_req, queue_purge_req, pc_wr_en, abort_irq}), 64'(0));

        // Vector table
        foreach (VECS[i]) run_abort(VECS[i], 1'b1);

        // R4 drain hold and R10 kill on a non-faulting channel
        begin
            int k;
            ch_inflight[1] = 1'b1;
            @(negedge clk);
            issue(2'd1, 2'd2, 1'b1, 32'h0000_0444);
            @(negedge clk);
            ch_abort_req = '0;
            k = 0;
            while (!queue_purge_req && k < 20) begin @(negedge clk); k++; end
            repeat (5) @(negedge clk);
            chk(!ch_fault[1] && ch_halt[1], "R4 no fault while in flight",
                64'({ch_fault[1], ch_halt[1]}), 64'(1));
            kill_one(2'd1, 1'b0);
            chk(ch_halt[1] && !ch_fault[1], "R10 kill ignored when not faulting",
                64'({ch_halt[1], ch_fault[1]}), 64'(2));
            ch_inflight[1] = 1'b0;
            k = 0;
            while (!ch_fault[1] && k < 10) begin @(negedge clk); k++; end
            chk(ch_fault[1] && ch_cause[3:2] == 2'd2, "R4 fault after drain release",
                64'({ch_fault[1], ch_cause[3:2]}), 64'(6));
            kill_one(2'd1, 1'b0);
        end

        // R8 simultaneous aborts on channels 3 and 1
        begin
            int k;
            logic [IW-1:0] first_inv = '1;
            bit seen_inv = 1'b0;
            bit order_ok = 1'b1;
            @(negedge clk);
            issue(2'd3, 2'd2, 1'b0, 32'h0);
            issue(2'd1, 2'd0, 1'b0, 32'h0);
            @(negedge clk);
            ch_abort_req = '0;
            chk(ch_halt[3] && ch_halt[1], "R8 both halted", 64'(ch_halt), 64'(4'b1010));
            k = 0;
            while (!(ch_fault[3] && ch_fault[1]) && k < 60) begin
                if (cache_inv_req && !seen_inv) begin seen_inv = 1'b1; first_inv = cache_inv_ch; end
                if (ch_fault[3] && !ch_fault[1]) order_ok = 1'b0;
                @(negedge clk); k++;
            end
            chk(first_inv == 2'd1 && order_ok, "R8 lowest channel first",
                64'(first_inv), 64'(1));
            chk(ch_cause[7:6] == 2'd2 && ch_cause[3:2] == 2'd0, "R8 R6 causes kept",
                64'(ch_cause), 64'(8'b1000_0000));
            kill_one(2'd3, 1'b0);
            kill_one(2'd1, 1'b0);
        end

        // R9 abort on a faulting channel is ignored
        begin
            int inv_n = 0;
            run_abort('{ch: 2'd0, cause: 2'd0, precise: 1'b0, pc: 32'h0}, 1'b0);
            @(negedge clk);
            issue(2'd0, 2'd3, 1'b1, 32'h0000_0888);
            @(negedge clk);
            ch_abort_req = '0;
            for (int k = 0; k < 10; k++) begin
                if (cache_inv_req || pc_wr_en) inv_n++;
                @(negedge clk);
            end
            chk(inv_n == 0, "R9 no new sequence", 64'(inv_n), 64'(0));
            chk(ch_cause[1:0] == 2'd0 && ch_fault[0], "R9 first cause kept",
                64'(ch_cause[1:0]), 64'(0));
            kill_one(2'd0, 1'b0);
        end

        // R11 manager abort
        begin
            int inv_n = 0;
            @(negedge clk);
            mgr_abort_req = 1'b1; mgr_abort_cause = 2'd3;
            @(negedge clk);
            mgr_abort_req = 1'b0;
            chk(mgr_fault && mgr_cause == 2'd3, "R11 manager fault recorded",
                64'({mgr_fault, mgr_cause}), 64'(7));
            chk(abort_irq && abort_irq_sb, "R7 irq on manager fault",
                64'({abort_irq, abort_irq_sb}), 64'(3));
            for (int k = 0; k < 5; k++) begin
                if (cache_inv_req || ch_halt != 0) inv_n++;
                @(negedge clk);
            end
            chk(inv_n == 0, "R11 no channel sequence", 64'(inv_n), 64'(0));
            kill_one(2'd0, 1'b1);
            chk(!mgr_fault && !abort_irq, "R11 manager kill clears",
                64'({mgr_fault, abort_irq}), 64'(0));
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule